// File: doc/BRIEF.md
# Floating-Point Status Bit Clear Unit

This unit executes one instruction: the one that forces a single bit of the 32-bit floating-point status and control register to zero. Each cycle it may receive an instruction word with a valid strobe. It checks that the opcode fields identify the bit-clear instruction and that the reserved field is empty. It then clears the status bit chosen by the instruction's 5-bit index. After the clear it recomputes the two summary bits so that they agree with the exception and enable bits.

The status register is numbered big-endian. Bit 0 is the most significant bit (vector index 31), and bit k sits at vector index 31-k. Bit 0 is the exception summary, bit 1 is the enabled-exception summary, bit 2 is the invalid-operation summary and bit 3 is the overflow exception. When the instruction's record bit is set, the unit also writes those four bits, taken from the updated register, into condition-register field 1. Both the clear and the field write complete in one clock.

The rest of the floating-point unit writes whole register values through a load port. A load and an instruction may arrive in the same cycle; the instruction then works on the freshly loaded value. The unit never touches the fixed-point exception register.

Top module: `fpscr_clear_unit`

## Requirements
- R1: A synchronous reset sets `fpscr` to 0, `crField` to 0, and `crWe` and `unrecognised` to 0.
- R2: An instruction is recognised only when all three of these hold: `instWord[31:26]` is 63, `instWord[10:1]` is 70, and `instWord[20:11]` is zero. These are big-endian bits 0-5, 21-30 and 11-20. The bit index is `instWord[25:21]` and the record flag is `instWord[0]`.
- R3: A recognised instruction whose index k is neither 1 nor 2 clears `fpscr[31-k]` at the next clock edge. Every bit other than the two summaries (indices 30 and 29) keeps its value.
- R4: An index of 1 or 2 clears nothing directly. The two summary bits are still recomputed.
- R5: After every recognised instruction, the invalid-operation summary `fpscr[29]` equals the OR of `fpscr[24:19]` and `fpscr[10:8]`.
- R6: After every recognised instruction, `fpscr[30]` equals the OR of five products: `fpscr[29]&fpscr[7]`, `fpscr[28]&fpscr[6]`, `fpscr[27]&fpscr[5]`, `fpscr[26]&fpscr[4]` and `fpscr[25]&fpscr[3]`.
- R7: A recognised instruction with the record flag at 1 pulses `crWe` for one cycle. In that same cycle `crField` equals `fpscr[31:28]` of the updated register, laid out as {FX, FEX, VX, OX}.
- R8: A recognised instruction with the record flag at 0 leaves `crWe` low and `crField` unchanged.
- R9: A valid word that is not recognised pulses `unrecognised` for one cycle. It leaves `crField` unchanged, and it leaves `fpscr` unchanged apart from any same-cycle load.
- R10: With `wrEn` at 1, the register takes `wrData` exactly as given. An instruction in the same cycle operates on `wrData` instead of the old value.
- R11: With `instValid` and `wrEn` both at 0, `fpscr` holds its value and neither pulse output rises, whatever `instWord` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Instruction word present this cycle |
| instWord | input | 32 | Instruction word |
| wrEn | input | 1 | Whole-register load from the rest of the unit |
| wrData | input | 32 | Value loaded when `wrEn` is high |
| fpscr | output | 32 | Current status and control register |
| crField | output | 4 | Condition-register field 1 value {FX, FEX, VX, OX} |
| crWe | output | 1 | One-cycle write enable for `crField` |
| unrecognised | output | 1 | One-cycle flag for a valid but unrecognised word |

## Verification
Several properties are checked on every cycle:
- the summary bits stay consistent with the source bits after each recognised instruction;
- the selected bit reads zero afterwards;
- the field write mirrors the top four register bits;
- rejected words and idle cycles leave the register untouched.

What the properties cannot show is the exact register value for a given starting value. That includes the protection of big-endian bits 1 and 2, which must keep summaries that are true rather than cleared, and the load-then-clear ordering within a single cycle. The bench's vector table and directed cases pin those down against values worked out by hand.

// File: rtl/fcu_pkg.sv
`timescale 1ns/1ps
package fcu_pkg;
  localparam int WORD_W     = 32;
  localparam int BT_W       = 5;
  localparam int CR_W       = 4;
  localparam int PRIMARY_OP = 63;
  localparam int EXT_OP     = 70;

  // big-endian bit names
  localparam int FX_BIT  = 0;
  localparam int FEX_BIT = 1;
  localparam int VX_BIT  = 2;
  localparam int OX_BIT  = 3;

  // invalid-operation sources: two contiguous groups
  localparam int VXA_LO = 7;
  localparam int VXA_N  = 6;
  localparam int VXB_LO = 21;
  localparam int VXB_N  = 3;
  localparam int VX_SRC_N = VXA_N + VXB_N;

  // exception k pairs with enable k + EN_OFFSET
  localparam int EXC_LO    = 2;
  localparam int EXC_HI    = 6;
  localparam int EN_OFFSET = 22;
  localparam int PAIR_N    = EXC_HI - EXC_LO + 1;

  function automatic int msbIdx(input int k);
    return WORD_W - 1 - k;
  endfunction

  function automatic int vxSrc(input int i);
    return (i < VXA_N) ? (VXA_LO + i) : (VXB_LO + i - VXA_N);
  endfunction

  typedef struct packed {
    logic            doLoad;
    logic            doExec;
    logic            clearEn;
    logic            doRecord;
    logic            flagBad;
    logic [BT_W-1:0] btSel;
  } fcuStrobe_t;
endpackage

// File: rtl/fcu_ctrl.sv
`timescale 1ns/1ps
module fcu_ctrl
  import fcu_pkg::*;
(
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord,
  input  logic              wrEn,
  output fcuStrobe_t        strobe
);
  localparam int OP_HI = msbIdx(0);
  localparam int OP_LO = msbIdx(5);
  localparam int BT_HI = msbIdx(6);
  localparam int BT_LO = msbIdx(10);
  localparam int RS_HI = msbIdx(11);
  localparam int RS_LO = msbIdx(20);
  localparam int XO_HI = msbIdx(21);
  localparam int XO_LO = msbIdx(30);
  localparam int RC_AT = msbIdx(31);
  localparam int OP_W  = OP_HI - OP_LO + 1;
  localparam int XO_W  = XO_HI - XO_LO + 1;

  logic opOk, xoOk, rsvdOk, recog;
  logic [BT_W-1:0] btField;

  assign opOk    = instWord[OP_HI:OP_LO] == OP_W'(PRIMARY_OP);
  assign xoOk    = instWord[XO_HI:XO_LO] == XO_W'(EXT_OP);
  assign rsvdOk  = ~|instWord[RS_HI:RS_LO];
  assign recog   = opOk & xoOk & rsvdOk;
  assign btField = instWord[BT_HI:BT_LO];

  always_comb begin
    strobe          = '0;
    strobe.doLoad   = wrEn;
    strobe.btSel    = btField;
    strobe.doExec   = instValid & recog;
    strobe.clearEn  = instValid & recog &
                      (btField != BT_W'(FEX_BIT)) & (btField != BT_W'(VX_BIT));
    strobe.doRecord = instValid & recog & instWord[RC_AT];
    strobe.flagBad  = instValid & ~recog;
  end
endmodule

// File: rtl/fcu_summary.sv
`timescale 1ns/1ps
module fcu_summary
  import fcu_pkg::*;
(
  input  logic [WORD_W-1:0] stateIn,
  output logic [WORD_W-1:0] stateOut
);
  logic [VX_SRC_N-1:0] vxSrcBits;
  logic [PAIR_N-1:0]   excBit;
  logic [PAIR_N-1:0]   pairHit;
  logic                vxNew;

  for (genvar i = 0; i < VX_SRC_N; i++) begin : g_vxsrc
    assign vxSrcBits[i] = stateIn[msbIdx(vxSrc(i))];
  end
  assign vxNew = |vxSrcBits;

  for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
    localparam int EN_POS = msbIdx(EXC_LO + p + EN_OFFSET);
    if (EXC_LO + p == VX_BIT) begin : g_vx
      assign excBit[p] = vxNew;
    end else begin : g_plain
      localparam int EXC_POS = msbIdx(EXC_LO + p);
      assign excBit[p] = stateIn[EXC_POS];
    end
    assign pairHit[p] = excBit[p] & stateIn[EN_POS];
  end

  always_comb begin
    stateOut                  = stateIn;
    stateOut[msbIdx(VX_BIT)]  = vxNew;
    stateOut[msbIdx(FEX_BIT)] = |pairHit;
  end
endmodule

// File: rtl/fcu_datapath.sv
`timescale 1ns/1ps
module fcu_datapath
  import fcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  fcuStrobe_t        strobe,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] fpscrQ,
  output logic [CR_W-1:0]   crQ,
  output logic              crWeQ,
  output logic              badQ
);
  logic [WORD_W-1:0] baseVal, clrMask, clearedVal, summedVal, nextVal;
  logic [BT_W-1:0]   clrIdx;

  assign clrIdx = BT_W'(WORD_W - 1) - strobe.btSel;

  always_comb begin
    baseVal = strobe.doLoad ? wrData : fpscrQ;
    clrMask = '0;
    if (strobe.clearEn) clrMask[clrIdx] = 1'b1;
    clearedVal = baseVal & ~clrMask;
  end

  fcu_summary summary_i (
    .stateIn  (clearedVal),
    .stateOut (summedVal)
  );

  assign nextVal = strobe.doExec ? summedVal : baseVal;

  always_ff @(posedge clk) begin
    if (rst) begin
      fpscrQ <= '0;
      crQ    <= '0;
      crWeQ  <= 1'b0;
      badQ   <= 1'b0;
    end else begin
      fpscrQ <= nextVal;
      crWeQ  <= strobe.doRecord;
      badQ   <= strobe.flagBad;
      if (strobe.doRecord)
        crQ <= {summedVal[msbIdx(FX_BIT)], summedVal[msbIdx(FEX_BIT)],
                summedVal[msbIdx(VX_BIT)], summedVal[msbIdx(OX_BIT)]};
    end
  end
endmodule

// File: rtl/fpscr_clear_unit.sv
`timescale 1ns/1ps
module fpscr_clear_unit
  import fcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] fpscr,
  output logic [CR_W-1:0]   crField,
  output logic              crWe,
  output logic              unrecognised
);
  fcuStrobe_t strobe;

  fcu_ctrl ctrl_i (
    .instValid (instValid),
    .instWord  (instWord),
    .wrEn      (wrEn),
    .strobe    (strobe)
  );

  fcu_datapath dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wrData (wrData),
    .fpscrQ (fpscr),
    .crQ    (crField),
    .crWeQ  (crWe),
    .badQ   (unrecognised)
  );
endmodule

// File: rtl/fcu_checker.sv
`timescale 1ns/1ps
module fcu_checker (
  input logic        clk,
  input logic        rst,
  input logic        instValid,
  input logic [31:0] instWord,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] fpscr,
  input logic [3:0]  crField,
  input logic        crWe,
  input logic        unrecognised
);
  logic       recogC;
  logic [4:0] btC;
  logic [4:0] btIdxQ;

  assign recogC = (instWord[31:26] == 6'd63) && (instWord[10:1] == 10'd70) &&
                  (instWord[20:11] == 10'd0);
  assign btC    = instWord[25:21];

  always_ff @(posedge clk) btIdxQ <= 5'd31 - btC;

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (fpscr == 32'd0 && crField == 4'd0 && !crWe && !unrecognised));

  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (instValid && recogC && btC != 5'd1 && btC != 5'd2) |=> fpscr[btIdxQ] == 1'b0);

  a_r5_vx: assert property (@(posedge clk) disable iff (rst)
    (instValid && recogC) |=> fpscr[29] == ((|fpscr[24:19]) | (|fpscr[10:8])));

  a_r6_fex: assert property (@(posedge clk) disable iff (rst)
    (instValid && recogC) |=> fpscr[30] == ((fpscr[29] & fpscr[7]) | (fpscr[28] & fpscr[6]) |
                                            (fpscr[27] & fpscr[5]) | (fpscr[26] & fpscr[4]) |
                                            (fpscr[25] & fpscr[3])));

  a_r7_record: assert property (@(posedge clk) disable iff (rst)
    (instValid && recogC && instWord[0]) |=> (crWe && crField == fpscr[31:28]));

  a_r8_no_record: assert property (@(posedge clk) disable iff (rst)
    !(instValid && recogC && instWord[0]) |=> (!crWe && $stable(crField)));

  a_r9_reject: assert property (@(posedge clk) disable iff (rst)
    (instValid && !recogC && !wrEn) |=> (unrecognised && $stable(fpscr)));

  a_r10_load: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !instValid) |=> fpscr == $past(wrData));

  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    (!instValid && !wrEn) |=> (!unrecognised && !crWe && $stable(fpscr)));
endmodule

bind fpscr_clear_unit fcu_checker chk_i (
  .clk          (clk),
  .rst          (rst),
  .instValid    (instValid),
  .instWord     (instWord),
  .wrEn         (wrEn),
  .wrData       (wrData),
  .fpscr        (fpscr),
  .crField      (crField),
  .crWe         (crWe),
  .unrecognised (unrecognised)
);

// File: tb/fpscr_clear_unit_tb_top.sv
`timescale 1ns/1ps
module fpscr_clear_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        instValid;
  logic [31:0] instWord;
  logic        wrEn;
  logic [31:0] wrData;
  logic [31:0] fpscr;
  logic [3:0]  crField;
  logic        crWe;
  logic        unrecognised;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fpscr_clear_unit dut_i (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .wrEn(wrEn), .wrData(wrData), .fpscr(fpscr), .crField(crField),
    .crWe(crWe), .unrecognised(unrecognised)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [31:0] pre;
    logic [31:0] inst;
    logic [31:0] expF;
    logic        expWe;
    logic [3:0]  expCr;
    logic        expBad;
  } vec_t;

  localparam int NV = 11;
  // word = 0xFC00008C | (bt << 21) | rc ; each vector loads pre and issues inst together
  localparam vec_t VECS [NV] = '{
    '{"R3 ", 32'hFFFFFFFF, 32'hFC60008D, 32'hEFFFFFFF, 1'b1, 4'hE, 1'b0}, // bt3 rc1
    '{"R7 ", 32'h10000000, 32'hFC00008D, 32'h10000000, 1'b1, 4'h1, 1'b0}, // bt0, OX kept
    '{"R6 ", 32'h10000040, 32'hFC00008D, 32'h50000040, 1'b1, 4'h5, 1'b0}, // OX&OE -> FEX
    '{"R4 ", 32'h60800080, 32'hFC40008D, 32'h60800080, 1'b1, 4'h6, 1'b0}, // bt2 keeps VX
    '{"R4 ", 32'h80000000, 32'hFC20008C, 32'h80000000, 1'b0, 4'h0, 1'b0}, // bt1 rc0
    '{"R3 ", 32'h00000001, 32'hFFE0008C, 32'h00000000, 1'b0, 4'h0, 1'b0}, // bt31
    '{"R5 ", 32'h00000780, 32'hFF00008D, 32'h20000700, 1'b1, 4'h2, 1'b0}, // bt24 clears VE
    '{"R6 ", 32'h05000010, 32'hFCE0008D, 32'h44000010, 1'b1, 4'h4, 1'b0}, // bt7, ZX&ZE
    '{"R9 ", 32'h12345678, 32'hFC60088D, 32'h12345678, 1'b0, 4'h0, 1'b1}, // reserved bit set
    '{"R2 ", 32'h12345678, 32'hF860008D, 32'h12345678, 1'b0, 4'h0, 1'b1}, // primary op 62
    '{"R2 ", 32'hABCDEF01, 32'hFC60008F, 32'hABCDEF01, 1'b0, 4'h0, 1'b1}  // extended op 71
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    instValid = 1'b0; wrEn = 1'b0; instWord = 32'hDEADBEEF; wrData = 32'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "fpscr", fpscr, 32'h0);
    check("R1", "crField", {28'h0, crField}, 32'h0);
    check("R1", "pulses", {30'h0, crWe, unrecognised}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      wrEn = 1'b1; wrData = VECS[i].pre; instValid = 1'b1; instWord = VECS[i].inst;
      @(negedge clk);
      check(string'(VECS[i].tag), "fpscr", fpscr, VECS[i].expF);
      check(string'(VECS[i].tag), "crWe", {31'h0, crWe}, {31'h0, VECS[i].expWe});
      check(string'(VECS[i].tag), "unrecognised", {31'h0, unrecognised}, {31'h0, VECS[i].expBad});
      if (VECS[i].expWe) check("R7", "crField", {28'h0, crField}, {28'h0, VECS[i].expCr});
    end

    // R11 idle with garbage word
    idle(); @(negedge clk);
    check("R11", "fpscr stable", fpscr, 32'hABCDEF01);
    check("R11", "pulses low", {30'h0, crWe, unrecognised}, 32'h0);

    // R10 load alone keeps inconsistent summaries as given
    wrEn = 1'b1; wrData = 32'h60000000; @(negedge clk);
    check("R10", "load as given", fpscr, 32'h60000000);
    // instruction alone on held state: bt3 rc1
    idle(); instValid = 1'b1; instWord = 32'hFC60008D; @(negedge clk);
    check("R5", "summaries recomputed", fpscr, 32'h00000000);
    check("R7", "crField zero", {28'h0, crField}, 32'h0);

    // R8: record then non-record keeps field
    idle(); wrEn = 1'b1; wrData = 32'h10000040; instValid = 1'b1; instWord = 32'hFC00008D;
    @(negedge clk);
    check("R7", "crField", {28'h0, crField}, 32'h5);
    idle(); instValid = 1'b1; instWord = 32'hFFE0008C; @(negedge clk);
    check("R8", "crWe low", {31'h0, crWe}, 32'h0);
    check("R8", "crField held", {28'h0, crField}, 32'h5);
    check("R8", "fpscr", fpscr, 32'h50000040);

    // R9 reject without load keeps register
    idle(); instValid = 1'b1; instWord = 32'hFC60108C; @(negedge clk);
    check("R9", "fpscr held", fpscr, 32'h50000040);
    check("R9", "flag", {31'h0, unrecognised}, 32'h1);
    check("R9", "crField held", {28'h0, crField}, 32'h5);
    idle(); @(negedge clk);
    check("R9", "flag one cycle", {31'h0, unrecognised}, 32'h0);

    // R1 reset mid-run with activity
    rst = 1'b1; instValid = 1'b1; instWord = 32'hFC00008D; @(negedge clk);
    check("R1", "fpscr after reset", fpscr, 32'h0);
    check("R1", "crField after reset", {28'h0, crField}, 32'h0);
    check("R1", "pulses after reset", {30'h0, crWe, unrecognised}, 32'h0);
    rst = 1'b0; idle(); @(negedge clk);

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule